// File: doc/BRIEF.md
# Single-Cycle Backplane Bus Master Sequencer

This block turns one command from a local port into one interlocked single read or write cycle on a parallel backplane bus. A command carries an address, a six-bit modifier code, a transfer size, a direction, a choice of which data strobe leads, and write data. The sequencer puts the address phase on the bus, raises the address strobe, and raises the data strobes once the slave has released every termination line. It then waits for an acknowledge, a bus error or a retry, and sends read data and a status back on the response port. All bus-side ports are active high: 1 means asserted. Open-drain buffering and inversion are left to the pad ring.

The three termination inputs each pass through two flip-flops before the state machine looks at them. A timeout ends a cycle that no slave terminates. Commands that ask for 64-bit data, or that carry a modifier for 40-bit or 64-bit addressing or for 64-bit multiplexed block moves, are refused at the command port and never reach the bus. With `pipe_en` set, the next command is taken while the slave still holds its termination, and its address phase is driven right away.

States: `ST_IDLE` (waiting for a command), `ST_ADDR` (address phase only), `ST_ASTB` (address strobe on, waiting for all terminations low), `ST_STRB_A` (leading strobe on), `ST_WAIT` (all strobes on, waiting for a termination or the timeout), `ST_RELEASE` (strobes and address strobe off, waiting for the slave to release). Transitions:
- IDLE→ADDR on a legal command.
- ADDR→ASTB after one cycle.
- ASTB→STRB_A once the synchronised terminations are clear.
- STRB_A→WAIT after one cycle.
- WAIT→RELEASE on a termination or timeout.
- RELEASE, once clear, goes to ASTB if a pipelined command is pending, to ADDR if a command is accepted on that same edge, and to IDLE otherwise.

Top module: `bus_cycle_master`

## Requirements
- R1: Address, modifier and long-word lines hold their values for at least one clock before the address strobe rises, and they stay unchanged while it is high. The interrupt-acknowledge line stays negated at all times.
- R2: A write command asserts the write line and enables the write data drivers from the address strobe onward. A read keeps both negated. The write line is steady whenever a data strobe is high.
- R3: No data strobe rises unless the synchronised acknowledge, bus error and retry lines were all negated on the edge before. Because of the two-flop synchronisers, every termination input must be low for at least two sampled clocks first.
- R4: Lane encoding depends on `cmd_size` (0 byte, 1 16-bit, 2 24-bit, 3 32-bit) and on address bits 0 and 1. A byte uses `bus_ds[1]` for an even address and `bus_ds[0]` for an odd one, with long-word negated and A01 taken from the address. 16-bit uses both strobes, long-word negated and A01 from the address. 24-bit uses one strobe chosen by address bit 0 as for a byte, with long-word asserted and A01 forced to 0. 32-bit uses both strobes, long-word asserted and A01 0.
- R5: When both strobes are used, the strobe chosen by `cmd_lead_upper` (1: `bus_ds[1]`) rises alone one clock before the other. The two never rise on the same edge.
- R6: An acknowledge with neither bus error nor retry gives status 0. For a read, `rsp_rdata` carries `bus_rdata` as sampled at that edge. On every other outcome `rsp_rdata` is 0. The strobes and the address strobe fall together on the edge that raises `rsp_valid` for one clock.
- R7: A bus error gives status 1. A retry gives status 2. Retry wins when both arrive together.
- R8: If no termination arrives within `TMO_CYC` clocks in `ST_WAIT`, the cycle ends with status 1.
- R9: A command with `cmd_size` above 3, or with a modifier in {0x00, 0x01, 0x03, 0x04, 0x08, 0x0C, 0x20, 0x21, 0x34, 0x35, 0x37, 0x38, 0x3C}, is answered with status 3. It raises no address strobe and leaves the address lines unchanged.
- R10: With `pipe_en` set, a command is accepted during `ST_RELEASE` and its address is driven while the slave still holds its termination. The address strobe rises only after that termination is released. With `pipe_en` clear, `cmd_ready` stays low until the cycle is fully released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_en | input | 1 | Allow early address drive for the next command |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_mod | input | MOD_W | Address modifier code |
| cmd_size | input | 3 | 0 byte, 1 16-bit, 2 24-bit, 3 32-bit, others refused |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_lead_upper | input | 1 | Which strobe leads when both are used |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_status | output | 2 | 0 ok, 1 error or timeout, 2 retry, 3 refused |
| rsp_rdata | output | DATA_W | Read data |
| bus_addr | output | ADDR_W-1 | Address lines A01 and up |
| bus_mod | output | MOD_W | Modifier lines |
| bus_lword | output | 1 | Long-word line |
| bus_iack | output | 1 | Interrupt-acknowledge line, held negated |
| bus_as | output | 1 | Address strobe |
| bus_write | output | 1 | Write line |
| bus_ds | output | 2 | Data strobes |
| bus_wdata | output | DATA_W | Write data onto the bus |
| bus_data_oe | output | 1 | Write data driver enable |
| bus_rdata | input | DATA_W | Data from the bus |
| bus_dtack | input | 1 | Acknowledge from the slave |
| bus_berr | input | 1 | Bus error from the slave |
| bus_retry | input | 1 | Retry from the slave |

## Verification
Some rules are checked by assertions on every clock. The address phase is stable across the rise of the address strobe. No strobe rises after a clock in which any synchronised termination was seen. The two strobes never rise together. The write line stays steady under the strobes. The address strobe and the strobes fall together. Other behaviour only shows in the bench's scenarios against a behavioural slave: the lane encoding for each size and address alignment, the status priority and read data, the timeout, refused commands leaving the bus quiet, and the early address drive seen while a slave is still holding its acknowledge.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ASTB,
        ST_STRB_A,
        ST_WAIT,
        ST_RELEASE
    } bcm_state_e;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_ERR    = 2'd1,
        RSP_RETRY  = 2'd2,
        RSP_REJECT = 2'd3
    } bcm_status_e;

    localparam logic [2:0] SZ_BYTE = 3'd0;
    localparam logic [2:0] SZ_HALF = 3'd1;
    localparam logic [2:0] SZ_TRI  = 3'd2;
    localparam logic [2:0] SZ_WORD = 3'd3;

    localparam int TERM_N = 3;   // dtack, berr, retry
endpackage

// File: rtl/bcm_term_sync.sv
module bcm_term_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/bcm_lane_decode.sv
module bcm_lane_decode
    import bcm_pkg::*;
#(
    parameter int MOD_W = 6
) (
    input  logic [2:0]       size,
    input  logic             a0,
    input  logic             a1,
    input  logic [MOD_W-1:0] mod,
    input  logic             lead_upper,
    output logic             legal,
    output logic [1:0]       ds_mask,
    output logic [1:0]       lead_mask,
    output logic             lword,
    output logic             a01
);
    logic size_ok, mod_ok;

    always_comb begin
        size_ok = 1'b1;
        ds_mask = 2'b00;
        lword   = 1'b0;
        a01     = a1;
        unique case (size)
            SZ_BYTE: ds_mask = a0 ? 2'b01 : 2'b10;
            SZ_HALF: ds_mask = 2'b11;
            SZ_TRI: begin
                ds_mask = a0 ? 2'b01 : 2'b10;
                lword   = 1'b1;
                a01     = 1'b0;
            end
            SZ_WORD: begin
                ds_mask = 2'b11;
                lword   = 1'b1;
                a01     = 1'b0;
            end
            default: size_ok = 1'b0;
        endcase
        // wide-address and 64-bit data modifiers are not single cycles
        mod_ok = !(mod inside {6'h00, 6'h01, 6'h03, 6'h04, 6'h08, 6'h0C,
                               6'h20, 6'h21, 6'h34, 6'h35, 6'h37, 6'h38, 6'h3C});
        legal     = size_ok && mod_ok;
        lead_mask = (ds_mask == 2'b11) ? (lead_upper ? 2'b10 : 2'b01) : ds_mask;
    end
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bcm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int MOD_W   = 6,
    parameter int TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_en,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [MOD_W-1:0]  cmd_mod,
    input  logic [2:0]        cmd_size,
    input  logic              cmd_write,
    input  logic              cmd_lead_upper,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:1] bus_addr,
    output logic [MOD_W-1:0]  bus_mod,
    output logic              bus_lword,
    output logic              bus_iack,
    output logic              bus_as,
    output logic              bus_write,
    output logic [1:0]        bus_ds,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_dtack,
    input  logic              bus_berr,
    input  logic              bus_retry
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);

    bcm_state_e        state, state_nx;
    logic [ADDR_W-1:0] c_addr;
    logic [MOD_W-1:0]  c_mod;
    logic [2:0]        c_size;
    logic              c_write, c_lead;
    logic [DATA_W-1:0] c_wdata;
    logic              pend;
    logic [TMO_W-1:0]  tmo;
    logic              tmo_hit;
    logic [TERM_N-1:0] term_s;
    logic              t_ack, t_err, t_rty, any_term;
    logic              accept;

    logic       in_legal, cur_legal;
    logic [1:0] in_mask, in_lead, cur_mask, cur_lead;
    logic       in_lw, in_a01, cur_lw, cur_a01;

    bcm_term_sync #(.W(TERM_N)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_retry, bus_berr, bus_dtack}), .q(term_s)
    );
    assign {t_rty, t_err, t_ack} = term_s;
    assign any_term = |term_s;

    bcm_lane_decode #(.MOD_W(MOD_W)) i_dec_in (
        .size(cmd_size), .a0(cmd_addr[0]), .a1(cmd_addr[1]), .mod(cmd_mod),
        .lead_upper(cmd_lead_upper), .legal(in_legal), .ds_mask(in_mask),
        .lead_mask(in_lead), .lword(in_lw), .a01(in_a01)
    );

    bcm_lane_decode #(.MOD_W(MOD_W)) i_dec_cur (
        .size(c_size), .a0(c_addr[0]), .a1(c_addr[1]), .mod(c_mod),
        .lead_upper(c_lead), .legal(cur_legal), .ds_mask(cur_mask),
        .lead_mask(cur_lead), .lword(cur_lw), .a01(cur_a01)
    );

    assign accept  = cmd_valid && cmd_ready;
    assign tmo_hit = (tmo == TMO_W'(TMO_CYC - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept && in_legal) state_nx = ST_ADDR;
            ST_ADDR:    state_nx = ST_ASTB;
            ST_ASTB:    if (!any_term) state_nx = ST_STRB_A;
            ST_STRB_A:  state_nx = ST_WAIT;
            ST_WAIT:    if (any_term || tmo_hit) state_nx = ST_RELEASE;
            ST_RELEASE: if (!any_term) begin
                if (pend)                       state_nx = ST_ASTB;
                else if (accept && in_legal)    state_nx = ST_ADDR;
                else                            state_nx = ST_IDLE;
            end
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            c_addr     <= '0;
            c_mod      <= '0;
            c_size     <= SZ_BYTE;
            c_write    <= 1'b0;
            c_lead     <= 1'b0;
            c_wdata    <= '0;
            pend       <= 1'b0;
            tmo        <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= RSP_OK;
            rsp_rdata  <= '0;
        end else begin
            state     <= state_nx;
            rsp_valid <= 1'b0;
            if (accept && in_legal) begin
                c_addr  <= cmd_addr;
                c_mod   <= cmd_mod;
                c_size  <= cmd_size;
                c_write <= cmd_write;
                c_lead  <= cmd_lead_upper;
                c_wdata <= cmd_wdata;
            end
            if (accept && !in_legal) begin
                rsp_valid  <= 1'b1;
                rsp_status <= RSP_REJECT;
                rsp_rdata  <= '0;
            end
            if (state == ST_RELEASE && state_nx != ST_RELEASE)
                pend <= 1'b0;
            else if (state == ST_RELEASE && accept && in_legal)
                pend <= 1'b1;
            tmo <= (state == ST_WAIT) ? tmo + 1'b1 : '0;
            if (state == ST_WAIT && state_nx == ST_RELEASE) begin
                rsp_valid <= 1'b1;
                if (t_rty)      rsp_status <= RSP_RETRY;
                else if (t_err) rsp_status <= RSP_ERR;
                else if (t_ack) rsp_status <= RSP_OK;
                else            rsp_status <= RSP_ERR;
                rsp_rdata <= (t_ack && !t_err && !t_rty && !c_write) ? bus_rdata : '0;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready   = (state == ST_IDLE) || (state == ST_RELEASE && pipe_en && !pend);
        bus_as      = 1'b0;
        bus_write   = 1'b0;
        bus_data_oe = 1'b0;
        bus_ds      = 2'b00;
        unique case (state)
            ST_IDLE, ST_ADDR, ST_RELEASE: ;
            ST_ASTB: begin
                bus_as = 1'b1; bus_write = c_write; bus_data_oe = c_write;
            end
            ST_STRB_A: begin
                bus_as = 1'b1; bus_write = c_write; bus_data_oe = c_write;
                bus_ds = cur_lead;
            end
            ST_WAIT: begin
                bus_as = 1'b1; bus_write = c_write; bus_data_oe = c_write;
                bus_ds = cur_mask;
            end
            default: ;
        endcase
    end

    assign bus_addr  = {c_addr[ADDR_W-1:2], cur_a01};
    assign bus_mod   = c_mod;
    assign bus_lword = cur_lw;
    assign bus_iack  = 1'b0;
    assign bus_wdata = c_wdata;

    // R9 decode of the held command is always legal by the time it is driven
    a_r9_held_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> cur_legal);

    a_r1_addr_before_as: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as) |-> ($stable(bus_addr) && $stable(bus_mod) && $stable(bus_lword)));

    a_r10_addr_stable_under_as: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && $past(bus_as)) |-> $stable(bus_addr));

    a_r2_write_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_ds) |-> (bus_as && $stable(bus_write)));

    a_r3_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|bus_ds) |-> ($past(term_s) == '0));

    a_r5_single_lead: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ds) == 2'b00) |-> (bus_ds != 2'b11));

    a_r6_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> (bus_ds == 2'b00 && rsp_valid));
endmodule

// File: tb/test_bus_cycle_master.sv
module test_bus_cycle_master;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_en = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [5:0]  cmd_mod = '0;
    logic [2:0]  cmd_size = '0;
    logic        cmd_write = 1'b0;
    logic        cmd_lead_upper = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic [31:1] bus_addr;
    logic [5:0]  bus_mod;
    logic        bus_lword, bus_iack, bus_as, bus_write, bus_data_oe;
    logic [1:0]  bus_ds;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_dtack = 1'b0, bus_berr = 1'b0, bus_retry = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bus_cycle_master #(.TMO_CYC(TMO)) i_bus_cycle_master (
        .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_mod(cmd_mod), .cmd_size(cmd_size), .cmd_write(cmd_write),
        .cmd_lead_upper(cmd_lead_upper), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_mod(bus_mod), .bus_lword(bus_lword),
        .bus_iack(bus_iack), .bus_as(bus_as), .bus_write(bus_write),
        .bus_ds(bus_ds), .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe),
        .bus_rdata(bus_rdata), .bus_dtack(bus_dtack), .bus_berr(bus_berr),
        .bus_retry(bus_retry)
    );

    function automatic logic [31:0] slave_word(input logic [31:0] a);
        return a ^ 32'h5A3C_96E1;
    endfunction
    assign bus_rdata = slave_word({bus_addr, 1'b0});

    int checks = 0, errors = 0;
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // slave behaviour: 0 ack, 1 berr, 2 retry, 3 berr+retry, 4 silent
    int sl_mode = 0, sl_delay = 2, sl_hold = 1;
    bit term_on = 0;
    int cnt = 0, hold_cnt = 0;
    bit s_got = 0;
    logic [1:0]  s_ds; logic s_lw, s_wr, s_oe; logic [31:1] s_addr; logic [5:0] s_mod;
    logic [31:0] s_wdata; logic [1:0] first_ds;
    // monitors
    logic [31:1] p_addr = '0; logic [5:0] p_mod = '0; logic p_lw = 0, p_as = 0;
    logic [1:0]  p_ds = '0;
    int clr_cnt = 0, v_r1 = 0, v_r3 = 0, v_r10 = 0, iack_cnt = 0, as_rises = 0, pipe_seen = 0;

    always @(negedge clk) if (rst_n) begin
        if (bus_iack) iack_cnt++;
        if (bus_as && !p_as) begin
            as_rises++;
            if (bus_addr != p_addr || bus_mod != p_mod || bus_lword != p_lw) v_r1++;
            if (bus_dtack || bus_berr || bus_retry) v_r10++;
        end
        if (!bus_as && term_on && bus_addr != p_addr) pipe_seen++;
        if (bus_ds != 0 && p_ds == 0) begin
            first_ds = bus_ds;
            if (clr_cnt < 2) v_r3++;
        end
        clr_cnt = (bus_dtack || bus_berr || bus_retry) ? 0 : clr_cnt + 1;
        p_addr = bus_addr; p_mod = bus_mod; p_lw = bus_lword; p_as = bus_as; p_ds = bus_ds;
        // slave
        if (bus_ds != 0 && !term_on) begin
            cnt++;
            if (cnt == sl_delay) begin
                s_got = 1; s_ds = bus_ds; s_lw = bus_lword; s_wr = bus_write; s_oe = bus_data_oe;
                s_addr = bus_addr; s_mod = bus_mod; s_wdata = bus_wdata;
                if (sl_mode != 4) begin
                    term_on = 1;
                    bus_dtack <= (sl_mode == 0);
                    bus_berr  <= (sl_mode == 1 || sl_mode == 3);
                    bus_retry <= (sl_mode == 2 || sl_mode == 3);
                end
            end
        end else if (bus_ds == 0) begin
            cnt = 0;
            if (term_on) begin
                hold_cnt++;
                if (hold_cnt >= sl_hold) begin
                    term_on = 0; hold_cnt = 0;
                    bus_dtack <= 0; bus_berr <= 0; bus_retry <= 0;
                end
            end
        end
    end

    function automatic bit is_illegal(input logic [5:0] m, input logic [2:0] sz);
        return (sz > 3) || (m inside {6'h00, 6'h01, 6'h03, 6'h04, 6'h08, 6'h0C,
                                      6'h20, 6'h21, 6'h34, 6'h35, 6'h37, 6'h38, 6'h3C});
    endfunction
    function automatic logic [1:0] exp_mask(input logic [2:0] sz, input logic a0);
        return (sz == 1 || sz == 3) ? 2'b11 : (a0 ? 2'b01 : 2'b10);
    endfunction
    function automatic logic exp_a01(input logic [2:0] sz, input logic a1);
        return (sz >= 2) ? 1'b0 : a1;
    endfunction
    function automatic logic [1:0] exp_status(input int mode);
        case (mode)
            0: return 2'd0;
            1: return 2'd1;
            2, 3: return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    task automatic issue(input logic [31:0] a, input logic [5:0] m, input logic [2:0] sz,
                         input logic wr, input logic lead, input logic [31:0] wd);
        cmd_addr = a; cmd_mod = m; cmd_size = sz; cmd_write = wr;
        cmd_lead_upper = lead; cmd_wdata = wd; cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    logic [1:0] r_st; logic [31:0] r_dat; bit r_got;
    task automatic wait_rsp();
        r_got = 0;
        for (int i = 0; i < 300 && !r_got; i++) begin
            if (rsp_valid) begin r_got = 1; r_st = rsp_status; r_dat = rsp_rdata; end
            else @(negedge clk);
        end
        check(r_got, "R6 response arrives", {31'd0, r_got}, 32'd1);
    endtask

    task automatic run_cycle(input logic [31:0] a, input logic [5:0] m, input logic [2:0] sz,
                             input logic wr, input logic lead, input logic [31:0] wd, input int mode);
        logic [31:0] ea;
        sl_mode = mode; s_got = 0;
        issue(a, m, sz, wr, lead, wd);
        wait_rsp();
        ea = {a[31:2], exp_a01(sz, a[1]), 1'b0};
        check(r_st == exp_status(mode), mode == 4 ? "R8 timeout status" : "R7/R6 status",
              {30'd0, r_st}, {30'd0, exp_status(mode)});
        check(r_dat == ((mode == 0 && !wr) ? slave_word(ea) : 32'd0), "R6 read data",
              r_dat, (mode == 0 && !wr) ? slave_word(ea) : 32'd0);
        check(s_got, "R4 strobes seen", {31'd0, s_got}, 32'd1);
        check(s_ds == exp_mask(sz, a[0]), "R4 strobe mask", {30'd0, s_ds}, {30'd0, exp_mask(sz, a[0])});
        check(s_lw == (sz >= 2), "R4 long word", {31'd0, s_lw}, {31'd0, sz >= 2});
        check({s_addr, 1'b0} == ea && s_mod == m, "R4 address and modifier", {s_addr, 1'b0}, ea);
        check(s_wr == wr && s_oe == wr, "R2 write line", {30'd0, s_wr, s_oe}, {30'd0, wr, wr});
        if (wr) check(s_wdata == wd, "R2 write data", s_wdata, wd);
        if (exp_mask(sz, a[0]) == 2'b11)
            check(first_ds == (lead ? 2'b10 : 2'b01), "R5 lead strobe", {30'd0, first_ds},
                  {30'd0, lead ? 2'b10 : 2'b01});
        repeat (6) @(negedge clk);
    endtask

    task automatic run_all();
        int rises;
        logic [5:0] m;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state
        check(!bus_as && bus_ds == 0 && !rsp_valid && cmd_ready, "R1 reset idle",
              {29'd0, bus_as, bus_ds}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed lane cases
        run_cycle(32'h0000_1000, 6'h39, 3'd0, 0, 0, 0, 0);
        run_cycle(32'h0000_1001, 6'h39, 3'd0, 1, 0, 32'h1111_2222, 0);
        run_cycle(32'h0000_2002, 6'h29, 3'd1, 0, 1, 0, 0);
        run_cycle(32'h0000_2002, 6'h29, 3'd1, 0, 0, 0, 0);
        run_cycle(32'h0012_3401, 6'h3D, 3'd2, 1, 0, 32'hABCD_0123, 0);
        run_cycle(32'h8000_0006, 6'h09, 3'd3, 0, 1, 0, 0);
        // terminations
        run_cycle(32'h0000_3000, 6'h09, 3'd3, 0, 0, 0, 1);
        run_cycle(32'h0000_3004, 6'h09, 3'd3, 1, 1, 32'h5, 2);
        run_cycle(32'h0000_3008, 6'h0D, 3'd1, 0, 0, 0, 3);
        run_cycle(32'h0000_300C, 6'h0D, 3'd0, 0, 0, 0, 4);
        // refused commands
        for (int k = 0; k < 3; k++) begin
            rises = as_rises;
            sl_mode = 0;
            issue(32'hFFFF_0000, k == 0 ? 6'h0D : (k == 1 ? 6'h34 : 6'h0C), k == 0 ? 3'd4 : 3'd3, 0, 0, 0);
            wait_rsp();
            check(r_st == 2'd3, "R9 refused status", {30'd0, r_st}, 32'd3);
            repeat (4) @(negedge clk);
            check(as_rises == rises && bus_addr[31:16] != 16'hFFFF, "R9 bus quiet",
                  as_rises, rises);
        end
        // no pipelining with a long hold: ready held low
        sl_hold = 5; sl_mode = 0;
        issue(32'h0000_4000, 6'h09, 3'd3, 0, 0, 0);
        wait_rsp();
        #1;
        check(!cmd_ready, "R10 ready low without pipelining", {31'd0, cmd_ready}, 32'd0);
        repeat (10) @(negedge clk);
        check(pipe_seen == 0, "R10 no early address", pipe_seen, 0);
        // pipelined back-to-back
        pipe_en = 1'b1;
        issue(32'h0000_5000, 6'h09, 3'd3, 0, 0, 0);
        wait_rsp();
        check(r_st == 2'd0, "R10 first status", {30'd0, r_st}, 32'd0);
        @(negedge clk);
        issue(32'h0000_6004, 6'h09, 3'd3, 0, 1, 0);
        wait_rsp();
        check(r_st == 2'd0 && r_dat == slave_word(32'h0000_6004), "R10 second read", r_dat,
              slave_word(32'h0000_6004));
        check(pipe_seen > 0, "R10 early address seen", pipe_seen, 1);
        sl_hold = 1;
        repeat (8) @(negedge clk);
        pipe_en = 1'b0;
        // constrained random legal cycles
        for (int n = 0; n < 40; n++) begin
            logic [2:0] sz;
            sz = 3'($urandom_range(0, 3));
            do m = 6'($urandom()); while (is_illegal(m, sz));
            sl_delay = int'($urandom_range(2, 5));
            run_cycle($urandom(), m, sz, 1'($urandom()), 1'($urandom()), $urandom(),
                      int'($urandom_range(0, 3)));
        end
        check(v_r1 == 0 && iack_cnt == 0, "R1 address before strobe, iack negated", v_r1 + iack_cnt, 0);
        check(v_r3 == 0, "R3 interlock", v_r3, 0);
        check(v_r10 == 0, "R10 strobe after release", v_r10, 0);
    endtask

    initial begin
        bit wd = 0;
        fork
            run_all();
            begin repeat (150000) @(posedge clk); wd = 1; end
        join_any
        if (wd) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule